// File: doc/BRIEF.md
# Merging Miss Status Holding Table

This block keeps track of cache-line misses that are waiting on the next memory level. Every live entry belongs to one block address and keeps an ordered list of the request IDs that wait for that line. A client on the request side sees at once whether the address already has an entry (`req_hit`) and whether one more request can be taken for it (`req_full`). It then raises `req_add` to merge the request into the existing entry or to open a new one.

When the line comes back, the fill port marks the entry ready and returns the entry's atomic flag. Ready entries wait in first-in first-out order. The drain port shows the oldest request ID of the entry at the head of that order. Each `drain_pop` removes that ID. When the last ID is removed, the entry is released.

The fill port never stalls. Illegal operations are refused without touching any state, and they set a sticky error flag.

Top module: `mshr_merge_table`

## Requirements
- R1: `req_hit` is 1 in the same cycle exactly when a valid entry holds `req_addr`, and no two valid entries ever hold the same address.
- R2: When `req_addr` has an entry, `req_full` is 1 exactly when that entry already holds MERGE_MAX IDs.
- R3: When `req_addr` has no entry, `req_full` is 1 exactly when all ENTRIES entries are valid.
- R4: An accepted add (`req_add` with `req_full` 0) either appends `req_id` to the end of the matching entry's list or opens a new entry whose only ID is `req_id`. IDs of one entry drain in the order they were added.
- R5: An entry's atomic flag is the OR of `req_atomic` over every add into it. `fill_atomic` shows, in the same cycle, the flag of the entry matching `fill_addr` as held before the clock edge, and is 0 when there is no match.
- R6: An accepted fill makes `drain_ready` 1 from the next cycle on. Filled entries come out at the drain port in fill order.
- R7: While `drain_ready` is 1, `drain_id` and `drain_addr` show the oldest ID and the address of the head ready entry. `drain_pop` removes that ID. Removing the last ID frees the entry, so `req_hit` for its address is 0 in the next cycle and the next ready entry becomes the head.
- R8: `err` becomes 1 after any of these: an add while `req_full` is 1, a fill whose address has no entry, or a fill of an entry that is already ready. Such an operation changes no entry. `err` stays 1 until reset.
- R9: An add and a drain may fall in the same cycle. If the add merges into the head entry while its last ID is popped, the entry survives holding only the new ID and stays at the head.
- R10: A `drain_pop` while `drain_ready` is 0 has no effect.
- R11: After reset, no entry is valid, `drain_ready` is 0 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_addr | input | ADDR_W | Block address on the request port |
| req_id | input | ID_W | ID of the request to add |
| req_atomic | input | 1 | The request is atomic |
| req_add | input | 1 | Add or merge the request |
| req_hit | output | 1 | An entry for `req_addr` exists |
| req_full | output | 1 | No room for a request to `req_addr` |
| fill_valid | input | 1 | A fill response arrives |
| fill_addr | input | ADDR_W | Block address of the fill |
| fill_atomic | output | 1 | Atomic flag of the entry matching `fill_addr` |
| drain_ready | output | 1 | At least one ready entry is waiting |
| drain_pop | input | 1 | Remove the shown ID |
| drain_id | output | ID_W | Oldest ID of the head ready entry |
| drain_addr | output | ADDR_W | Address of the head ready entry |
| err | output | 1 | Sticky error flag |

## Verification
Two functions can meet in one cycle: an add, and a drain pop on the entry at the head of the ready order. The hard case is a merge into that same entry at the moment its last ID leaves. A directed step creates this case, and the random phase also produces it often, because it draws from only a few addresses and pops often. The bench judges the result against its own model, which applies the pop first, then the add, then the release. It then compares the hit, full, ready and head-ID outputs of the following cycles with that model.

// File: rtl/mshrt_pkg.sv
package mshrt_pkg;

  // Room check: merging is capped per entry, allocating is capped by table size.
  function automatic logic full_rule(input logic hit, input int unsigned cnt,
                                     input int unsigned nvalid,
                                     input int unsigned merge_max,
                                     input int unsigned entries);
    return hit ? (cnt >= merge_max) : (nvalid >= entries);
  endfunction

  // Pointer advance with wrap for a depth that need not be a power of two.
  function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/mshrt_entry.sv
module mshrt_entry #(
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 6,
  parameter int MERGE_MAX = 3,
  parameter int CNT_W     = $clog2(MERGE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              pop_i,
  input  logic              mark_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              atomic_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              atomic_o,
  output logic              ready_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ID_W-1:0]   head_id_o
);

  logic [ID_W-1:0]  ids_q [MERGE_MAX];
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] wr_idx;

  assign cnt_nxt   = cnt_o + CNT_W'(merge_i) - CNT_W'(pop_i);
  assign wr_idx    = cnt_o - CNT_W'(pop_i);
  assign head_id_o = ids_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      atomic_o <= 1'b0;
      ready_o  <= 1'b0;
      cnt_o    <= '0;
      for (int k = 0; k < MERGE_MAX; k++) ids_q[k] <= '0;
    end else if (alloc_i) begin
      valid_o  <= 1'b1;
      addr_o   <= addr_i;
      atomic_o <= atomic_i;
      ready_o  <= 1'b0;
      cnt_o    <= CNT_W'(1);
      ids_q[0] <= id_i;
    end else if (valid_o) begin
      if (pop_i)
        for (int k = 0; k < MERGE_MAX - 1; k++) ids_q[k] <= ids_q[k+1];
      if (merge_i)
        for (int k = 0; k < MERGE_MAX; k++)
          if (wr_idx == CNT_W'(k)) ids_q[k] <= id_i;
      cnt_o <= cnt_nxt;
      if (cnt_nxt == '0) begin
        valid_o  <= 1'b0;
        ready_o  <= 1'b0;
        atomic_o <= 1'b0;
      end else begin
        ready_o  <= ready_o | mark_i;
        atomic_o <= atomic_o | (merge_i & atomic_i);
      end
    end
  end

  // R4: a merge without a pop grows the list by one
  a_r4_append: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && merge_i && !pop_i && !alloc_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  // R7: popping the last ID with no merge frees the entry
  a_r7_free: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && pop_i && !merge_i && cnt_o == CNT_W'(1) |=> !valid_o);
  // R9: merge and pop together keep the entry alive
  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && pop_i && merge_i |=> valid_o);
  // R2: the list never exceeds the merge cap
  a_r2_cap: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> cnt_o <= CNT_W'(MERGE_MAX) && cnt_o != '0);

endmodule

// File: rtl/mshrt_rdyq.sv
module mshrt_rdyq #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  import mshrt_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign dout_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q <= PW'(wrap_inc(int'(wr_q), DEPTH));
      end
      if (pop_i) rd_q <= PW'(wrap_inc(int'(rd_q), DEPTH));
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // R6: one slot per entry, so the ready order never overflows
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i |-> cnt_q < CW'(DEPTH));
  // R10: only a non-empty ready order is popped
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/mshr_merge_table.sv
module mshr_merge_table #(
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 6,
  parameter int ENTRIES   = 4,
  parameter int MERGE_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_atomic,
  input  logic              req_add,
  output logic              req_hit,
  output logic              req_full,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              fill_atomic,
  output logic              drain_ready,
  input  logic              drain_pop,
  output logic [ID_W-1:0]   drain_id,
  output logic [ADDR_W-1:0] drain_addr,
  output logic              err
);
  import mshrt_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(MERGE_MAX + 1);
  localparam int NV_W  = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] e_valid, e_atomic, e_ready;
  logic [ENTRIES-1:0] req_match, fill_match;
  logic [ENTRIES-1:0] alloc_vec, merge_vec, pop_vec, mark_vec;
  logic [ADDR_W-1:0]  e_addr [ENTRIES];
  logic [CNT_W-1:0]   e_cnt  [ENTRIES];
  logic [ID_W-1:0]    e_head [ENTRIES];

  logic [IDX_W-1:0] hit_idx, fill_idx, free_idx, head_idx;
  logic [NV_W-1:0]  nvalid;

  // named internal events
  logic add_ok, add_merge, add_alloc, fill_hit, fill_ok, pop_ok, head_freed, q_empty;

  always_comb begin
    hit_idx  = '0;
    fill_idx = '0;
    free_idx = '0;
    nvalid   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      req_match[i]  = e_valid[i] && (e_addr[i] == req_addr);
      fill_match[i] = e_valid[i] && (e_addr[i] == fill_addr);
      if (req_match[i])  hit_idx  = IDX_W'(i);
      if (fill_match[i]) fill_idx = IDX_W'(i);
      nvalid = nvalid + NV_W'(e_valid[i]);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!e_valid[i]) free_idx = IDX_W'(i);
  end

  assign req_hit   = |req_match;
  assign req_full  = full_rule(req_hit, int'(e_cnt[hit_idx]), int'(nvalid), MERGE_MAX, ENTRIES);
  assign add_ok    = req_add && !req_full;
  assign add_merge = add_ok && req_hit;
  assign add_alloc = add_ok && !req_hit;

  assign fill_hit    = |fill_match;
  assign fill_ok     = fill_valid && fill_hit && !e_ready[fill_idx];
  assign fill_atomic = fill_hit && e_atomic[fill_idx];

  assign drain_ready = !q_empty;
  assign drain_id    = e_head[head_idx];
  assign drain_addr  = e_addr[head_idx];
  assign pop_ok      = drain_pop && drain_ready;
  assign head_freed  = pop_ok && (e_cnt[head_idx] == CNT_W'(1)) && !merge_vec[head_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign alloc_vec[g] = add_alloc && (free_idx == IDX_W'(g));
    assign merge_vec[g] = add_merge && (hit_idx  == IDX_W'(g));
    assign pop_vec[g]   = pop_ok    && (head_idx == IDX_W'(g));
    assign mark_vec[g]  = fill_ok   && (fill_idx == IDX_W'(g));

    mshrt_entry #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .MERGE_MAX(MERGE_MAX), .CNT_W(CNT_W)
    ) u_entry (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_vec[g]), .merge_i(merge_vec[g]),
      .pop_i(pop_vec[g]), .mark_i(mark_vec[g]),
      .addr_i(req_addr), .id_i(req_id), .atomic_i(req_atomic),
      .valid_o(e_valid[g]), .addr_o(e_addr[g]), .atomic_o(e_atomic[g]),
      .ready_o(e_ready[g]), .cnt_o(e_cnt[g]), .head_id_o(e_head[g])
    );
  end

  mshrt_rdyq #(.DEPTH(ENTRIES), .W(IDX_W)) u_rdyq (
    .clk(clk), .rst_n(rst_n),
    .push_i(fill_ok), .din_i(fill_idx),
    .pop_i(head_freed), .dout_o(head_idx), .empty_o(q_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else if ((req_add && req_full) || (fill_valid && !(fill_hit && !e_ready[fill_idx])))
      err <= 1'b1;
  end

  // R1: addresses are unique across valid entries
  a_r1_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_match));
  // R6: an accepted fill is visible at the drain port next cycle
  a_r6_fill_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> drain_ready);
  // R8: the error flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R8: a refused add leaves the valid set unchanged
  a_r8_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    req_add && req_full && !pop_ok |=> $stable(e_valid));

endmodule

// File: tb/test_mshr_merge_table.sv
module test_mshr_merge_table;
  localparam int AW = 16, IW = 6, NE = 4, MM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] req_addr = '0, fill_addr = '0;
  logic [IW-1:0] req_id = '0;
  logic req_atomic = 1'b0, req_add = 1'b0, fill_valid = 1'b0, drain_pop = 1'b0;
  logic req_hit, req_full, fill_atomic, drain_ready, err;
  logic [IW-1:0] drain_id;
  logic [AW-1:0] drain_addr;

  always #4 clk = ~clk;

  mshr_merge_table #(.ADDR_W(AW), .ID_W(IW), .ENTRIES(NE), .MERGE_MAX(MM)) i_mshr_merge_table (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_id(req_id),
    .req_atomic(req_atomic), .req_add(req_add), .req_hit(req_hit), .req_full(req_full),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_atomic(fill_atomic),
    .drain_ready(drain_ready), .drain_pop(drain_pop), .drain_id(drain_id),
    .drain_addr(drain_addr), .err(err)
  );

  int checks = 0, fails = 0;

  // reference model
  bit mv[NE], mat[NE], mr[NE];
  logic [AW-1:0] ma[NE];
  int mc[NE];
  int mid[NE][MM];
  int rq[NE];
  int rq_n = 0;
  bit merr = 0;

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic int nval();
    int n = 0;
    for (int i = 0; i < NE; i++) n += int'(mv[i]);
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit add, input logic [AW-1:0] a, input int id, input bit at,
                      input bit fv, input logic [AW-1:0] fa, input bit pop);
    int h, f, e, slot;
    bit exp_full, add_ok, fill_ok, pop_ok;
    @(negedge clk);
    req_add = add; req_addr = a; req_id = IW'(id); req_atomic = at;
    fill_valid = fv; fill_addr = fa; drain_pop = pop;
    #1;
    h = find(a);
    f = find(fa);
    exp_full = (h >= 0) ? (mc[h] >= MM) : (nval() >= NE);
    chk(req_hit == (h >= 0), "R1 hit", int'(req_hit), int'(h >= 0));
    chk(req_full == exp_full, (h >= 0) ? "R2 full" : "R3 full", int'(req_full), int'(exp_full));
    chk(fill_atomic == (f >= 0 && mat[f]), "R5 fill_atomic", int'(fill_atomic), int'(f >= 0 && mat[f]));
    chk(drain_ready == (rq_n > 0), "R6 drain_ready", int'(drain_ready), int'(rq_n > 0));
    if (rq_n > 0) begin
      chk(int'(drain_id) == mid[rq[0]][0], "R7 drain_id", int'(drain_id), mid[rq[0]][0]);
      chk(drain_addr == ma[rq[0]], "R7 drain_addr", int'(drain_addr), int'(ma[rq[0]]));
    end
    chk(err == merr, "R8 err", int'(err), int'(merr));
    @(posedge clk);
    add_ok  = add && !exp_full;
    fill_ok = fv && f >= 0 && !mr[f];
    pop_ok  = pop && rq_n > 0;
    if ((add && exp_full) || (fv && !fill_ok)) merr = 1;
    e = (rq_n > 0) ? rq[0] : -1;
    if (pop_ok) begin
      for (int k = 0; k < MM - 1; k++) mid[e][k] = mid[e][k+1];
      mc[e]--;
    end
    if (add_ok) begin
      if (h >= 0) begin
        mid[h][mc[h]] = id; mc[h]++; mat[h] |= at;
      end else begin
        slot = -1;
        for (int i = NE - 1; i >= 0; i--) if (!mv[i]) slot = i;
        mv[slot] = 1; ma[slot] = a; mat[slot] = at; mr[slot] = 0;
        mc[slot] = 1; mid[slot][0] = id;
      end
    end
    if (fill_ok) begin
      mr[f] = 1; rq[rq_n] = f; rq_n++;
    end
    if (pop_ok && mc[e] == 0) begin
      mv[e] = 0; mr[e] = 0; mat[e] = 0;
      for (int k = 0; k < NE - 1; k++) rq[k] = rq[k+1];
      rq_n--;
    end
    #1;
    req_add = 0; fill_valid = 0; drain_pop = 0;
  endtask

  task automatic look(input int exp_id, input bit exp_rdy, input bit exp_hit, input string tag);
    @(negedge clk); #1;
    chk(drain_ready == exp_rdy, tag, int'(drain_ready), int'(exp_rdy));
    if (exp_rdy) chk(int'(drain_id) == exp_id, tag, int'(drain_id), exp_id);
    chk(req_hit == exp_hit, tag, int'(req_hit), int'(exp_hit));
  endtask

  localparam logic [AW-1:0] A = 16'h0100, B = 16'h0200, C = 16'h0300, D = 16'h0400, E = 16'h0500;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11: reset state
    @(negedge clk); #1;
    chk(drain_ready == 0, "R11 drain_ready", int'(drain_ready), 0);
    chk(err == 0, "R11 err", int'(err), 0);
    chk(req_hit == 0, "R11 hit", int'(req_hit), 0);

    // R4: merge three IDs into A, R2: probe at the cap
    step(1, A, 1, 0, 0, 0, 0);
    step(1, A, 2, 0, 0, 0, 0);
    step(1, A, 3, 0, 0, 0, 0);
    step(0, A, 0, 0, 0, 0, 0);
    // R3: fill the table, R5: atomic on B
    step(1, B, 7, 0, 0, 0, 0);
    step(1, B, 8, 1, 0, 0, 0);
    step(1, C, 10, 0, 0, 0, 0);
    step(1, D, 11, 0, 0, 0, 0);
    step(0, E, 0, 0, 0, 0, 0);
    // R6: fill B then A, drain order follows fills
    step(0, E, 0, 0, 1, B, 0);
    step(0, E, 0, 0, 1, A, 0);
    look(7, 1, 0, "R6 head is B");
    step(0, B, 0, 0, 0, 0, 1);
    look(8, 1, 1, "R4 second B id");
    step(0, B, 0, 0, 0, 0, 1);
    look(1, 1, 0, "R7 B freed, A heads");
    step(0, A, 0, 0, 0, 0, 1);
    look(2, 1, 1, "R4 order A");
    step(0, A, 0, 0, 0, 0, 1);
    look(3, 1, 1, "R4 order A last");
    // R9: merge into A while its last ID leaves
    step(1, A, 9, 1, 0, 0, 1);
    look(9, 1, 1, "R9 entry kept");
    step(0, A, 0, 0, 0, 0, 1);
    look(0, 0, 0, "R7 A freed");
    // R10: pop with nothing ready
    step(0, C, 0, 0, 0, 0, 1);
    look(0, 0, 1, "R10 C untouched");
    step(0, C, 0, 0, 1, C, 0);
    look(10, 1, 1, "R10 C id intact");
    // R8: fill with no entry, and refill of a ready entry
    step(0, E, 0, 0, 1, E, 0);
    @(negedge clk); #1;
    chk(err == 1, "R8 err set", int'(err), 1);
    step(0, C, 0, 0, 1, C, 0);
    look(10, 1, 1, "R8 refill ignored");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] ra, rf;
      ra = AW'(16'h0010 + ($urandom % 6));
      rf = AW'(16'h0010 + ($urandom % 6));
      step(($urandom % 3) != 0, ra, int'($urandom % 64), ($urandom % 4) == 0,
           ($urandom % 3) == 0, rf, ($urandom % 2) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule